// File: doc/BRIEF.md
# Hierarchical Carry Lookahead Adder

This block adds two unsigned operands of a parameterised width and a carry-in. It returns the sum, of the same width, and a carry-out. The operands are cut into 4-bit slices. Each slice forms its own per-bit generate and propagate terms. Its internal carries come from flattened two-level sum-of-products equations, so no carry ripples through the slice's bits.

Each slice also reports a slice-level generate and propagate. A second lookahead level takes these and produces the carry into every slice. It reuses the same 4-bit carry unit over groups of four slices. The carry-out is the carry leaving the most significant slice.

By default the result is captured in an output register, so it appears one clock after the operands. Setting `OUT_REG` to 0 turns the block into a purely combinational adder.

Top module: `cla_adder_top`

## Requirements
- R1: `{carryOut, sumOut}` equals `opA + opB + carryIn` computed at WIDTH+1 bits, with sumOut the low WIDTH bits and carryOut bit WIDTH.
- R2: WIDTH must be a positive multiple of 4; any other value stops elaboration with an error.
- R3: Each sum bit is the XOR of that bit's propagate term (a XOR b) with the carry into the bit, and a bit generates a carry when both operand bits are 1. A lone carry entering through a run of propagating bits therefore flips every bit of that run.
- R4: When a slice generates a carry (its operand bits alone produce one), the carry out of that slice is 1 whatever its carry-in. For example, 0x00FF + 0x0001 gives 0x0100 with carryOut 0.
- R5: When every bit of a slice propagates, the slice passes its carry-in unchanged to its carry-out. For example, all-ones + 0 + carryIn=1 gives sum 0 and carryOut 1.
- R6: No slice reports generate and propagate at the same time.
- R7: With OUT_REG=1 (the default), the outputs change on the first rising clock edge after the operands change, and hold the value computed from the operands present at that edge.
- R8: While rstN is low, sumOut and carryOut are 0 whatever the operands are.
- R9: All-zero operands give sum equal to carryIn (0 or 1) and carryOut 0.
- R10: All-ones plus all-ones with carryIn=1 gives all-ones and carryOut 1. With carryIn=0 the sum is all-ones except bit 0, which is 0, and carryOut is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rstN | input | 1 | Asynchronous active-low reset; clears the output register |
| opA | input | WIDTH | First unsigned operand |
| opB | input | WIDTH | Second unsigned operand |
| carryIn | input | 1 | Carry into the least significant bit |
| sumOut | output | WIDTH | Sum, registered when OUT_REG=1 |
| carryOut | output | 1 | Carry out of the most significant slice |

## Verification
The clocked properties assume that opA, opB and carryIn are stable around each rising edge. They also assume these inputs carry known values whenever reset is released. The bench meets both conditions by changing inputs only on the falling edge, by driving defined values before rstN rises, and by reading the outputs one falling edge after the capturing edge. The slice-level properties assume no particular operand values, so random operands exercise them as fully as the directed corner vectors.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Strobes passed from the control unit to the output stage
  typedef struct packed {
    logic capture;  // load the register with the new result
    logic bypass;   // drive the combinational result straight out
  } claStrobe_t;

  localparam int unsigned SLICE_BITS = 4;

endpackage

// File: rtl/cla_carry4.sv
// Flattened 4-bit lookahead carry unit: every carry is a two-level SOP.
module cla_carry4 (
  input  logic [3:0] gen,
  input  logic [3:0] prop,
  input  logic       cIn,
  output logic [4:1] carry
);

  always_comb begin
    carry[1] = gen[0] | (prop[0] & cIn);
    carry[2] = gen[1] | (prop[1] & gen[0]) | (prop[1] & prop[0] & cIn);
    carry[3] = gen[2] | (prop[2] & gen[1]) | (prop[2] & prop[1] & gen[0])
             | (prop[2] & prop[1] & prop[0] & cIn);
    carry[4] = gen[3] | (prop[3] & gen[2]) | (prop[3] & prop[2] & gen[1])
             | (prop[3] & prop[2] & prop[1] & gen[0])
             | (prop[3] & prop[2] & prop[1] & prop[0] & cIn);
  end

endmodule

// File: rtl/cla_slice4.sv
// One 4-bit adder slice: per-bit terms, local carries, sums, slice G/P.
module cla_slice4 (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cIn,
  output logic [3:0] sum,
  output logic       sliceGen,
  output logic       sliceProp
);

  logic [3:0] bitGen;
  logic [3:0] bitProp;
  logic [4:1] localCarry;
  logic       unusedTopCarry;

  // R3: per-bit generate and propagate; propagate reused for the sum
  assign bitGen  = a & b;
  assign bitProp = a ^ b;

  cla_carry4 u_carry (
    .gen   (bitGen),
    .prop  (bitProp),
    .cIn   (cIn),
    .carry (localCarry)
  );

  // The slice's own carry-out comes from the level above
  assign unusedTopCarry = localCarry[4];

  assign sum = bitProp ^ {localCarry[3:1], cIn};

  assign sliceGen  = bitGen[3] | (bitProp[3] & bitGen[2])
                   | (bitProp[3] & bitProp[2] & bitGen[1])
                   | (bitProp[3] & bitProp[2] & bitProp[1] & bitGen[0]);
  assign sliceProp = &bitProp;

endmodule

// File: rtl/cla_lookahead.sv
// Second level: carry into every slice from slice G/P, four slices per unit.
module cla_lookahead #(
  parameter int unsigned NUM_SLICES = 4
) (
  input  logic [NUM_SLICES-1:0] sliceGen,
  input  logic [NUM_SLICES-1:0] sliceProp,
  input  logic                  cIn,
  output logic [NUM_SLICES:0]   sliceCarry
);

  localparam int unsigned NUM_UNITS = (NUM_SLICES + 3) / 4;
  localparam int unsigned PAD_SLICES = NUM_UNITS * 4;

  logic [PAD_SLICES-1:0] genPad;
  logic [PAD_SLICES-1:0] propPad;
  logic [PAD_SLICES:1]   carryPad;
  logic [NUM_UNITS:0]    unitCarry;
  logic                  unusedPadCarry;

  // Pad missing slices with kill (G=0, P=0); their carries are discarded
  always_comb begin
    genPad  = '0;
    propPad = '0;
    genPad[NUM_SLICES-1:0]  = sliceGen;
    propPad[NUM_SLICES-1:0] = sliceProp;
  end

  assign unitCarry[0] = cIn;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    cla_carry4 u_carry (
      .gen   (genPad[4*u +: 4]),
      .prop  (propPad[4*u +: 4]),
      .cIn   (unitCarry[u]),
      .carry (carryPad[4*u+1 +: 4])
    );
    assign unitCarry[u+1] = carryPad[4*u+4];
  end

  assign unusedPadCarry = ^carryPad;
  assign sliceCarry = {carryPad[NUM_SLICES:1], cIn};

endmodule

// File: rtl/cla_datapath.sv
// Datapath: slices plus second-level lookahead.
module cla_datapath #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumComb,
  output logic             carryComb
);

  import cla_pkg::*;

  localparam int unsigned NUM_SLICES = WIDTH / SLICE_BITS;

  logic [NUM_SLICES-1:0] sliceGen;
  logic [NUM_SLICES-1:0] sliceProp;
  logic [NUM_SLICES:0]   sliceCarry;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    cla_slice4 u_slice (
      .a         (opA[SLICE_BITS*s +: SLICE_BITS]),
      .b         (opB[SLICE_BITS*s +: SLICE_BITS]),
      .cIn       (sliceCarry[s]),
      .sum       (sumComb[SLICE_BITS*s +: SLICE_BITS]),
      .sliceGen  (sliceGen[s]),
      .sliceProp (sliceProp[s])
    );

    // R4: a generating slice always produces a carry
    p_gen_forces_carry_r4 : assert property (@(posedge clk) disable iff (!rstN)
      sliceGen[s] |-> sliceCarry[s+1]);
    // R5: a fully propagating slice passes its carry-in through
    p_prop_passes_carry_r5 : assert property (@(posedge clk) disable iff (!rstN)
      sliceProp[s] |-> (sliceCarry[s+1] == sliceCarry[s]));
    // R6: generate and propagate are exclusive per slice
    p_gen_prop_excl_r6 : assert property (@(posedge clk) disable iff (!rstN)
      !(sliceGen[s] && sliceProp[s]));
  end

  cla_lookahead #(.NUM_SLICES(NUM_SLICES)) u_lookahead (
    .sliceGen   (sliceGen),
    .sliceProp  (sliceProp),
    .cIn        (carryIn),
    .sliceCarry (sliceCarry)
  );

  assign carryComb = sliceCarry[NUM_SLICES];

endmodule

// File: rtl/cla_ctrl.sv
// Control: decides how the output stage behaves.
module cla_ctrl #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 rstN,
  output cla_pkg::claStrobe_t  strobe
);

  always_comb begin
    strobe.bypass  = !OUT_REG;
    strobe.capture = OUT_REG && rstN;
  end

endmodule

// File: rtl/cla_adder_top.sv
module cla_adder_top #(
  parameter int unsigned WIDTH   = 16,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  import cla_pkg::*;

  // R2: the width must split into whole 4-bit slices
  if ((WIDTH == 0) || (WIDTH % SLICE_BITS != 0)) begin : g_bad_width
    $error("cla_adder_top: WIDTH must be a positive multiple of 4");
  end

  logic [WIDTH-1:0] sumComb;
  logic             carryComb;
  claStrobe_t       strobe;

  cla_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .sumComb   (sumComb),
    .carryComb (carryComb)
  );

  cla_ctrl #(.OUT_REG(OUT_REG)) u_ctrl (
    .rstN   (rstN),
    .strobe (strobe)
  );

  if (OUT_REG) begin : g_reg
    logic [WIDTH-1:0] sumQ;
    logic             carryQ;
    logic             unusedBypass;

    assign unusedBypass = strobe.bypass;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sumQ   <= '0;
        carryQ <= 1'b0;
      end else if (strobe.capture) begin
        sumQ   <= sumComb;
        carryQ <= carryComb;
      end
    end

    assign sumOut   = sumQ;
    assign carryOut = carryQ;

    // R1, R7: registered result is the arithmetic sum of the prior operands
    p_sum_correct_r1 : assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> ({carryOut, sumOut} ==
                ({1'b0, $past(opA)} + {1'b0, $past(opB)} + (WIDTH+1)'($past(carryIn)))));
    // R9: zero operands yield the carry-in alone
    p_zero_operands_r9 : assert property (@(posedge clk) disable iff (!rstN)
      ((opA == '0) && (opB == '0)) |=> ((sumOut == WIDTH'($past(carryIn))) && !carryOut));
  end else begin : g_comb
    logic unusedStrobe;
    assign unusedStrobe = strobe.capture ^ strobe.bypass;
    assign sumOut   = sumComb;
    assign carryOut = carryComb;
  end

endmodule

// File: tb/test_cla_adder_top.sv
module test_cla_adder_top;

  localparam int unsigned WIDTH = 16;
  localparam int unsigned NVEC  = 10;

  // {opA, opB, carryIn, expCarry, expSum}
  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic        cin;
    logic        expC;
    logic [15:0] expS;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000},  // R9
    '{16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0001},  // R9
    '{16'hFFFF, 16'h0000, 1'b1, 1'b1, 16'h0000},  // R5
    '{16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF},  // R10
    '{16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 16'hFFFE},  // R10
    '{16'h1234, 16'h4321, 1'b0, 1'b0, 16'h5555},  // R1
    '{16'h00FF, 16'h0001, 1'b0, 1'b0, 16'h0100},  // R4
    '{16'h8000, 16'h8000, 1'b0, 1'b1, 16'h0000},  // R4
    '{16'h0F0F, 16'hF0F0, 1'b1, 1'b1, 16'h0000},  // R3
    '{16'h0F0F, 16'hF0F0, 1'b0, 1'b0, 16'hFFFF}   // R3
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [WIDTH-1:0] opA = '0;
  logic [WIDTH-1:0] opB = '0;
  logic             carryIn = 1'b0;
  logic [WIDTH-1:0] sumOut;
  logic             carryOut;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  bit          done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cla_adder_top #(.WIDTH(WIDTH)) i_cla_adder_top (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  task automatic check(input string req, input logic [WIDTH:0] got, input logic [WIDTH:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive on a falling edge, read back one falling edge later (R7)
  task automatic apply(input string req, input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input logic cin, input logic [WIDTH:0] exp);
    @(negedge clk);
    opA = a; opB = b; carryIn = cin;
    @(negedge clk);
    check(req, {carryOut, sumOut}, exp);
  endtask

  initial begin
    logic [15:0] lfsrA;
    logic [15:0] lfsrB;
    // R8: reset holds outputs at zero even with live operands
    opA = 16'hABCD; opB = 16'h7777; carryIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset", {carryOut, sumOut}, '0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      apply("R1 table", VECS[i].a, VECS[i].b, VECS[i].cin, {VECS[i].expC, VECS[i].expS});
    end

    // R7: output waits for the edge, then holds
    @(negedge clk);
    opA = 16'h0001; opB = 16'h0002; carryIn = 1'b0;
    #1 check("R7 before edge", {carryOut, sumOut}, 17'h0FFFF);
    @(negedge clk);
    check("R7 after edge", {carryOut, sumOut}, 17'h00003);

    // R1, R3: pseudo-random operands against behavioural sum
    lfsrA = 16'hACE1;
    lfsrB = 16'h1D2B;
    for (int i = 0; i < 200; i++) begin
      lfsrA = {lfsrA[14:0], lfsrA[15] ^ lfsrA[13] ^ lfsrA[12] ^ lfsrA[10]};
      lfsrB = {lfsrB[14:0], lfsrB[15] ^ lfsrB[13] ^ lfsrB[12] ^ lfsrB[10]};
      apply("R1 random", lfsrA, lfsrB, lfsrA[3],
            {1'b0, lfsrA} + {1'b0, lfsrB} + 17'(lfsrA[3]));
    end

    // R8: asynchronous reset mid-run clears outputs
    @(negedge clk);
    rstN = 1'b0;
    #1 check("R8 async clear", {carryOut, sumOut}, '0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule